// File: doc/BRIEF.md
# Audio Channel Interrupt Register Bank

This block collects the interrupt sources of a multi-channel audio serial port and presents them to software as two groups of memory-mapped registers on a 32-bit register bus with a 4-byte stride. The first group holds per-channel events in four classes of eight bits each: transmit ready, transmit underrun, receive ready and receive overflow. The second group holds port-wide events: a write error and four FIFO conditions.

Each group offers an enable register (write ones to set mask bits), a disable register (write ones to clear mask bits), a readable mask register and a readable status register. Ready-type status bits follow their source level. Error-type status bits latch a single-cycle event pulse and are cleared by reading the status register of their group. A bit is pending when it is set in both mask and status, and one level interrupt line is high while anything is pending in either group.

The bus is a single-cycle access: a select, a write strobe, a byte address and write data, with read data returned combinationally in the access cycle. Side effects of a read take place at the clock edge that ends the access.

Top module: `aud_irq_bank`

## Requirements
- R1: After reset both mask registers and both status registers read zero and `irq_o` is low.
- R2: A write to 0x10 (group A) or 0x20 (group B) sets every mask bit whose data bit is one and leaves every other mask bit unchanged; the masks read back at 0x18 (A) and 0x28 (B) in the cycle after the write.
- R3: A write to 0x14 (group A) or 0x24 (group B) clears every mask bit whose data bit is one and leaves every other mask bit unchanged.
- R4: The group A status register at 0x1C holds, for channel n, transmit ready at bit n, transmit underrun at bit 8+n, receive ready at bit 16+n and receive overflow at bit 24+n; an input change appears in the register one clock edge later.
- R5: The group B status register at 0x2C holds write error at bit 0, transmit FIFO ready at bit 8, transmit FIFO empty at bit 9, receive FIFO ready at bit 12 and receive FIFO full at bit 13; all other group B bits of mask and status read zero and cannot be enabled.
- R6: Underrun, overflow and write-error status bits stay set after their one-cycle pulse until the status register of their own group is read; that read returns the set bits and clears them, and a read of the other group does not clear them.
- R7: Ready-type status bits follow the live source level one edge later, are never latched and are not changed by a status read.
- R8: An event pulse arriving in the same cycle as a read of its status register is not lost: the read returns the previous value and the next read shows the new event.
- R9: `irq_o` is high exactly when some bit is set in both mask and status of the same group, in either group, and low when no such bit exists.
- R10: The enable and disable registers and every unmapped address read zero, and writes to the mask and status addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| tx_ready_i | input | NUM_CH | Per-channel transmit ready level |
| tx_underrun_i | input | NUM_CH | Per-channel transmit underrun pulse |
| rx_ready_i | input | NUM_CH | Per-channel receive ready level |
| rx_overflow_i | input | NUM_CH | Per-channel receive overflow pulse |
| wr_error_i | input | 1 | Write error pulse |
| txfifo_ready_i | input | 1 | Transmit FIFO ready level |
| txfifo_empty_i | input | 1 | Transmit FIFO empty level |
| rxfifo_ready_i | input | 1 | Receive FIFO ready level |
| rxfifo_full_i | input | 1 | Receive FIFO full level |
| irq_o | output | 1 | Level interrupt request |

## Verification
The properties take for granted that every event and level input is synchronous to the clock and stable around the rising edge, and that the live-level property compares the register to the input value seen at the previous edge. The bench respects this by changing all inputs and bus signals only on the falling edge and by holding every input at zero while reset is asserted. Error inputs are treated as pulses, so the bench raises them for exactly one cycle, sometimes on several channels at once and sometimes in the very cycle of a status read.

// File: rtl/aud_irq_pkg.sv
package aud_irq_pkg;

    localparam int REG_W  = 32;
    localparam int ADDR_W = 8;
    localparam int CLASS_W = 8;

    // register offsets (software visible)
    localparam logic [ADDR_W-1:0] OFF_ENA_A = 8'h10;
    localparam logic [ADDR_W-1:0] OFF_DIS_A = 8'h14;
    localparam logic [ADDR_W-1:0] OFF_MSK_A = 8'h18;
    localparam logic [ADDR_W-1:0] OFF_STS_A = 8'h1C;
    localparam logic [ADDR_W-1:0] OFF_ENA_B = 8'h20;
    localparam logic [ADDR_W-1:0] OFF_DIS_B = 8'h24;
    localparam logic [ADDR_W-1:0] OFF_MSK_B = 8'h28;
    localparam logic [ADDR_W-1:0] OFF_STS_B = 8'h2C;

    // group A: underrun and overflow classes latch
    localparam logic [REG_W-1:0] A_STICKY = 32'hFF00_FF00;
    // group B: implemented bits and the latched one
    localparam logic [REG_W-1:0] B_IMPL   = 32'h0000_3301;
    localparam logic [REG_W-1:0] B_STICKY = 32'h0000_0001;

    typedef enum logic [3:0] {
        RS_NONE,
        RS_ENA_A, RS_DIS_A, RS_MSK_A, RS_STS_A,
        RS_ENA_B, RS_DIS_B, RS_MSK_B, RS_STS_B
    } reg_sel_e;

    function automatic logic [REG_W-1:0] a_impl(input int n_ch);
        logic [CLASS_W-1:0] one;
        one = '0;
        for (int i = 0; i < CLASS_W; i++) one[i] = (i < n_ch);
        return {4{one}};
    endfunction

endpackage

// File: rtl/aud_irq_decode.sv
module aud_irq_decode
    import aud_irq_pkg::*;
(
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output reg_sel_e          hit,
    output logic              wr_stb,
    output logic              rd_stb
);

    always_comb begin
        unique case (bus_addr)
            OFF_ENA_A: hit = RS_ENA_A;
            OFF_DIS_A: hit = RS_DIS_A;
            OFF_MSK_A: hit = RS_MSK_A;
            OFF_STS_A: hit = RS_STS_A;
            OFF_ENA_B: hit = RS_ENA_B;
            OFF_DIS_B: hit = RS_DIS_B;
            OFF_MSK_B: hit = RS_MSK_B;
            OFF_STS_B: hit = RS_STS_B;
            default:   hit = RS_NONE;
        endcase
        wr_stb = bus_sel &  bus_wr;
        rd_stb = bus_sel & ~bus_wr;
    end

endmodule

// File: rtl/aud_irq_mask.sv
module aud_irq_mask #(
    parameter int             W    = 32,
    parameter logic [W-1:0]   IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_en,
    input  logic         clr_en,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask_o
);

    logic [W-1:0] mask_d, mask_q;

    always_comb begin
        mask_d = mask_q;
        if (set_en) mask_d = mask_d | (wdata & IMPL);
        if (clr_en) mask_d = mask_d & ~wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    assign mask_o = mask_q;

endmodule

// File: rtl/aud_irq_status.sv
module aud_irq_status #(
    parameter int           W      = 32,
    parameter logic [W-1:0] IMPL   = '1,
    parameter logic [W-1:0] STICKY = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    input  logic [W-1:0] evt_i,
    input  logic         rd_clr_i,
    output logic [W-1:0] sts_o
);

    typedef struct packed {
        logic [W-1:0] latched;
        logic [W-1:0] live;
    } sts_t;

    sts_t st_d, st_q;

    always_comb begin
        // clear by read first, then merge this cycle's events so none is lost
        st_d.latched = (st_q.latched & ~{W{rd_clr_i}}) | (evt_i & STICKY & IMPL);
        st_d.live    = lvl_i & ~STICKY & IMPL;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sts_o = st_q.latched | st_q.live;

endmodule

// File: rtl/aud_irq_bank.sv
module aud_irq_bank
    import aud_irq_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NUM_CH-1:0] tx_ready_i,
    input  logic [NUM_CH-1:0] tx_underrun_i,
    input  logic [NUM_CH-1:0] rx_ready_i,
    input  logic [NUM_CH-1:0] rx_overflow_i,
    input  logic              wr_error_i,
    input  logic              txfifo_ready_i,
    input  logic              txfifo_empty_i,
    input  logic              rxfifo_ready_i,
    input  logic              rxfifo_full_i,
    output logic              irq_o
);

    localparam logic [REG_W-1:0] A_IMPL = a_impl(NUM_CH);

    logic [CLASS_W-1:0] txr8, txu8, rxr8, rxo8;

    generate
        if (NUM_CH == CLASS_W) begin : g_full
            assign txr8 = tx_ready_i;
            assign txu8 = tx_underrun_i;
            assign rxr8 = rx_ready_i;
            assign rxo8 = rx_overflow_i;
        end else begin : g_pad
            assign txr8 = {{(CLASS_W-NUM_CH){1'b0}}, tx_ready_i};
            assign txu8 = {{(CLASS_W-NUM_CH){1'b0}}, tx_underrun_i};
            assign rxr8 = {{(CLASS_W-NUM_CH){1'b0}}, rx_ready_i};
            assign rxo8 = {{(CLASS_W-NUM_CH){1'b0}}, rx_overflow_i};
        end
    endgenerate

    reg_sel_e hit;
    logic     wr_stb, rd_stb;

    aud_irq_decode u_dec (
        .bus_sel (bus_sel),
        .bus_wr  (bus_wr),
        .bus_addr(bus_addr),
        .hit     (hit),
        .wr_stb  (wr_stb),
        .rd_stb  (rd_stb)
    );

    logic [REG_W-1:0] lvl_a, evt_a, lvl_b, evt_b;
    assign lvl_a = {8'h00, rxr8, 8'h00, txr8};
    assign evt_a = {rxo8, 8'h00, txu8, 8'h00};
    assign lvl_b = {18'b0, rxfifo_full_i, rxfifo_ready_i, 2'b0,
                    txfifo_empty_i, txfifo_ready_i, 8'b0};
    assign evt_b = {31'b0, wr_error_i};

    logic [REG_W-1:0] mask_a, mask_b, sts_a, sts_b;

    aud_irq_mask #(.W(REG_W), .IMPL(A_IMPL)) u_mask_a (
        .clk   (clk),
        .rst_n (rst_n),
        .set_en(wr_stb && hit == RS_ENA_A),
        .clr_en(wr_stb && hit == RS_DIS_A),
        .wdata (bus_wdata),
        .mask_o(mask_a)
    );

    aud_irq_mask #(.W(REG_W), .IMPL(B_IMPL)) u_mask_b (
        .clk   (clk),
        .rst_n (rst_n),
        .set_en(wr_stb && hit == RS_ENA_B),
        .clr_en(wr_stb && hit == RS_DIS_B),
        .wdata (bus_wdata),
        .mask_o(mask_b)
    );

    aud_irq_status #(.W(REG_W), .IMPL(A_IMPL), .STICKY(A_STICKY)) u_sts_a (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl_i   (lvl_a),
        .evt_i   (evt_a),
        .rd_clr_i(rd_stb && hit == RS_STS_A),
        .sts_o   (sts_a)
    );

    aud_irq_status #(.W(REG_W), .IMPL(B_IMPL), .STICKY(B_STICKY)) u_sts_b (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl_i   (lvl_b),
        .evt_i   (evt_b),
        .rd_clr_i(rd_stb && hit == RS_STS_B),
        .sts_o   (sts_b)
    );

    always_comb begin
        bus_rdata = '0;
        if (rd_stb) begin
            case (hit)
                RS_MSK_A: bus_rdata = mask_a;
                RS_STS_A: bus_rdata = sts_a;
                RS_MSK_B: bus_rdata = mask_b;
                RS_STS_B: bus_rdata = sts_b;
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign irq_o = (|(mask_a & sts_a)) | (|(mask_b & sts_b));

endmodule

// File: rtl/aud_irq_bank_chk.sv
module aud_irq_bank_chk
    import aud_irq_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [7:0]        bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [NUM_CH-1:0] tx_ready_i,
    input logic [NUM_CH-1:0] tx_underrun_i,
    input logic              wr_error_i,
    input logic [31:0]       mask_a,
    input logic [31:0]       mask_b,
    input logic [31:0]       status_a,
    input logic [31:0]       status_b,
    input logic              irq_o
);

    localparam logic [31:0] A_IMPL = a_impl(NUM_CH);

    logic ena_a_wr, dis_a_wr, sts_a_rd;
    assign ena_a_wr = bus_sel &&  bus_wr && bus_addr == OFF_ENA_A;
    assign dis_a_wr = bus_sel &&  bus_wr && bus_addr == OFF_DIS_A;
    assign sts_a_rd = bus_sel && !bus_wr && bus_addr == OFF_STS_A;

    assert_enable_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ena_a_wr |=> ((mask_a & $past(bus_wdata & A_IMPL)) == $past(bus_wdata & A_IMPL)));

    assert_zero_bits_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ena_a_wr |=> ((mask_a & ~$past(bus_wdata)) == ($past(mask_a) & ~$past(bus_wdata))));

    assert_disable_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dis_a_wr |=> ((mask_a & $past(bus_wdata)) == 32'h0));

    assert_live_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (status_a[0 +: NUM_CH] == $past(tx_ready_i)));

    assert_sticky_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !sts_a_rd |=> ((status_a & A_STICKY & $past(status_a)) == ($past(status_a) & A_STICKY)));

    assert_event_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|tx_underrun_i) |=> ((status_a[8 +: NUM_CH] & $past(tx_underrun_i)) == $past(tx_underrun_i)));

    assert_write_error_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_error_i |=> status_b[0]);

    assert_quiet_without_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_a == 32'h0 && mask_b == 32'h0) |-> !irq_o);

endmodule

bind aud_irq_bank aud_irq_bank_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_sel      (bus_sel),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .tx_ready_i   (tx_ready_i),
    .tx_underrun_i(tx_underrun_i),
    .wr_error_i   (wr_error_i),
    .mask_a       (mask_a),
    .mask_b       (mask_b),
    .status_a     (sts_a),
    .status_b     (sts_b),
    .irq_o        (irq_o)
);

// File: tb/aud_irq_bank_bench.sv
`timescale 1ns/1ps
module aud_irq_bank_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  txr = '0, txu = '0, rxr = '0, rxo = '0;
    logic        werr = 1'b0, tfr = 1'b0, tfe = 1'b0, rfr = 1'b0, rff = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;

    always #2.5 clk = ~clk;

    aud_irq_bank #(.NUM_CH(8)) u_aud_irq_bank (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_ready_i(txr), .tx_underrun_i(txu), .rx_ready_i(rxr), .rx_overflow_i(rxo),
        .wr_error_i(werr), .txfifo_ready_i(tfr), .txfifo_empty_i(tfe),
        .rxfifo_ready_i(rfr), .rxfifo_full_i(rff), .irq_o(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bwrite(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic read_with_unf(input logic [7:0] unf, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 8'h1C; txu = unf;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; txu = '0;
    endtask

    task automatic pulse(input logic [7:0] unf, input logic [7:0] ovf, input logic we);
        @(negedge clk);
        txu = unf; rxo = ovf; werr = we;
        @(negedge clk);
        txu = '0; rxo = '0; werr = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        logic [32:0] cum;
        logic [31:0] exp;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1 irq during reset", {31'b0, irq}, 32'h0);
        rst_n = 1'b1;

        // R1: reset state
        bread(8'h18, rd); chk("R1 mask A", rd, 32'h0);
        bread(8'h28, rd); chk("R1 mask B", rd, 32'h0);
        bread(8'h1C, rd); chk("R1 status A", rd, 32'h0);
        bread(8'h2C, rd); chk("R1 status B", rd, 32'h0);
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);

        // R2: set one bit at a time, cumulative
        for (int i = 0; i < 32; i++) begin
            bwrite(8'h10, 32'h1 << i);
            bread(8'h18, rd);
            cum = (33'h1 << (i + 1)) - 33'h1;
            chk("R2 enable sweep A", rd, cum[31:0]);
        end
        // R3: clear alternate bits, then all
        bwrite(8'h14, 32'h5555_5555);
        bread(8'h18, rd); chk("R3 disable even A", rd, 32'hAAAA_AAAA);
        bwrite(8'h14, 32'h0000_0000);
        bread(8'h18, rd); chk("R3 zero write no effect A", rd, 32'hAAAA_AAAA);
        bwrite(8'h14, 32'hFFFF_FFFF);
        bread(8'h18, rd); chk("R3 disable all A", rd, 32'h0);

        // R5: group B only implemented bits enable; R2/R3 on group B
        bwrite(8'h20, 32'hFFFF_FFFF);
        bread(8'h28, rd); chk("R5 mask B implemented bits", rd, 32'h0000_3301);
        bwrite(8'h24, 32'h0000_0001);
        bread(8'h28, rd); chk("R3 disable B bit0", rd, 32'h0000_3300);
        bwrite(8'h24, 32'hFFFF_FFFF);
        bread(8'h28, rd); chk("R3 disable all B", rd, 32'h0);

        // R10: write-only and unmapped read zero; mask/status writes ignored
        bwrite(8'h10, 32'h0000_F0F0);
        bread(8'h10, rd); chk("R10 enable A reads zero", rd, 32'h0);
        bread(8'h14, rd); chk("R10 disable A reads zero", rd, 32'h0);
        bread(8'h20, rd); chk("R10 enable B reads zero", rd, 32'h0);
        bread(8'h24, rd); chk("R10 disable B reads zero", rd, 32'h0);
        bread(8'h30, rd); chk("R10 unmapped reads zero", rd, 32'h0);
        bwrite(8'h18, 32'hFFFF_FFFF);
        bread(8'h18, rd); chk("R10 mask write ignored", rd, 32'h0000_F0F0);
        bwrite(8'h1C, 32'hFFFF_FFFF);
        bread(8'h1C, rd); chk("R10 status write ignored", rd, 32'h0);
        bwrite(8'h14, 32'hFFFF_FFFF);

        // R4/R6/R7: channel sweep of group A layout
        for (int ch = 0; ch < 8; ch++) begin
            txr = 8'h1 << ch;
            rxr = 8'h1 << ((ch + 1) % 8);
            pulse(8'h1 << ch, 8'h1 << (7 - ch), 1'b0);
            exp = (32'h1 << ch) | (32'h1 << (8 + ch)) |
                  (32'h1 << (16 + (ch + 1) % 8)) | (32'h1 << (24 + 7 - ch));
            bread(8'h1C, rd); chk("R4 channel layout A", rd, exp);
            bread(8'h1C, rd);
            chk("R6 R7 read clears latched keeps live", rd,
                (32'h1 << ch) | (32'h1 << (16 + (ch + 1) % 8)));
            txr = '0; rxr = '0;
            bread(8'h1C, rd); chk("R7 live bits drop with level", rd, 32'h0);
        end

        // R5: group B level layout, all 16 patterns
        for (int p = 0; p < 16; p++) begin
            tfr = p[0]; tfe = p[1]; rfr = p[2]; rff = p[3];
            bread(8'h2C, rd);
            exp = (32'(p[1:0]) << 8) | (32'(p[3:2]) << 12);
            chk("R5 FIFO bit layout B", rd, exp);
        end
        tfr = 1'b0; tfe = 1'b0; rfr = 1'b0; rff = 1'b0;

        // R6: each group's read clears only its own latched bits
        pulse(8'h08, 8'h00, 1'b1);
        bread(8'h1C, rd); chk("R6 underrun latched", rd, 32'h0000_0800);
        bread(8'h2C, rd); chk("R6 write error survives A read", rd, 32'h1);
        bread(8'h2C, rd); chk("R6 write error cleared by B read", rd, 32'h0);
        bread(8'h1C, rd); chk("R6 underrun cleared", rd, 32'h0);

        // R8: event in the read cycle is kept
        pulse(8'h04, 8'h00, 1'b0);
        read_with_unf(8'h20, rd); chk("R8 read returns prior value", rd, 32'h0000_0400);
        bread(8'h1C, rd); chk("R8 same-cycle event kept", rd, 32'h0000_2000);
        bread(8'h1C, rd); chk("R8 then cleared", rd, 32'h0);

        // R9: interrupt requires mask and status together
        bwrite(8'h10, 32'h0000_0100);
        pulse(8'h02, 8'h00, 1'b0);
        chk("R9 unmasked event no irq", {31'b0, irq}, 32'h0);
        pulse(8'h01, 8'h00, 1'b0);
        chk("R9 masked event raises irq", {31'b0, irq}, 32'h1);
        bread(8'h1C, rd);
        chk("R9 irq drops after clear-read", {31'b0, irq}, 32'h0);
        bwrite(8'h14, 32'hFFFF_FFFF);

        bwrite(8'h20, 32'h0000_1000);
        rfr = 1'b1;
        @(negedge clk);
        chk("R9 group B level irq", {31'b0, irq}, 32'h1);
        bwrite(8'h24, 32'h0000_1000);
        chk("R9 irq drops with mask B", {31'b0, irq}, 32'h0);
        rfr = 1'b0;

        for (int i = 0; i < 8; i++) begin
            bwrite(8'h10, 32'h1 << i);
            txr = 8'h1 << ((i + 1) % 8);
            @(negedge clk);
            chk("R9 other channel no irq", {31'b0, irq}, 32'h0);
            txr = 8'h1 << i;
            @(negedge clk);
            chk("R9 matching channel irq", {31'b0, irq}, 32'h1);
            txr = '0;
            bwrite(8'h14, 32'h0000_00FF);
        end

        finish_run();
    end

endmodule